// File: doc/BRIEF.md
# Core Reset Release Sequencer

This block decides the cycle in which a small processor core may leave reset. After a power-on event it runs a power-up delay, timed in ticks of a slow RC oscillator. It then counts main-oscillator cycles so that a crystal or resonator can settle. It holds the core reset output until every stage that applies has finished. A qualified low-supply indication from an external brown-out comparator holds the core in reset while the supply is low. When the supply recovers, the block runs the power-up delay again. A wake-from-sleep event reruns only the oscillator settling count. The external active-low reset pin is brought into the clock domain through a synchronizer. The pin gates the reset output but does not stop the timers, so a pin held low past the delays releases the core at once when it rises.

The block also holds a two-bit reset-cause register. Software writes it and hardware only clears it. Bit 1 is the power-on flag and bit 0 is the brown-out flag. A two-bit phase output shows how far the sequence has got: 0 hold, 1 power-up delay, 2 oscillator settling, 3 running.

The controller has six states:
- START: the first state after power-on.
- HOLD: held in brown-out.
- PWRT_POR: power-up delay after power-on.
- PWRT_BOR: power-up delay after brown-out.
- OST: oscillator settling.
- RUN: running.

The transitions are:
- START→PWRT_POR when the delay applies. Otherwise START→OST in crystal modes, or START→RUN.
- PWRT_POR→OST or PWRT_POR→RUN on delay done, depending on the mode.
- PWRT_BOR→RUN on delay done.
- OST→RUN on count done.
- RUN→OST on wake in crystal modes.
- any state→HOLD on brown-out.
- HOLD→PWRT_BOR when the supply recovers.

Top module: `rst_seq_top`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1, `phase_o` is 0 and `status_o[1]` (power-on flag) is 0.
- R2: After power-on, the power-up delay (phase 1) runs when `cfg_pwrt_n_i` is 0 or `cfg_bor_en_i` is 1. It lasts exactly PWRT_TICKS cycles in which `rc_tick_i` is high. Otherwise phase 1 is skipped.
- R3: Oscillator settling (phase 2) lasts exactly OST_CYCLES clock cycles. After power-on it follows the delay, or starts directly when the delay is off. It is used only when `osc_mode_i` is 0, 1 or 2 (crystal modes) and is skipped when `osc_mode_i` is 3 (RC).
- R4: `core_rst_o` is 0 only in phase 3 with the synchronized pin high. A rise of `mclr_n_i` reaches the output at the second rising clock edge after it.
- R5: A low `mclr_n_i` does not stop or alter the timer sequence, which still reaches phase 3 while the core stays in reset.
- R6: With `cfg_bor_en_i`=1, `supply_low_i`=1 forces phase 0 at the next edge and holds it while the supply is low. On recovery a delay of PWRT_TICKS ticks runs, followed by phase 3 with no oscillator settling.
- R7: A supply dip during the post-brown-out delay restarts that delay from zero.
- R8: With `cfg_bor_en_i`=0, `supply_low_i` has no effect on phase, reset output or status.
- R9: `wake_i` in phase 3 in a crystal mode starts oscillator settling without the power-up delay. In RC mode it is ignored.
- R10: A one-cycle `sw_wr_i` loads `sw_wdata_i` into the status register, which reads back on `status_o`.
- R11: Hardware clears the brown-out flag (bit 0) whenever a brown-out is active, with priority over a write, and never touches bit 1 except at power-on. The value of bit 0 after power-on is not meaningful.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| por_i | input | 1 | Power-on event, active high, asynchronous |
| supply_low_i | input | 1 | Qualified low-supply indication, synchronous |
| mclr_n_i | input | 1 | External reset pin, active low, asynchronous |
| wake_i | input | 1 | Wake-from-sleep pulse |
| cfg_pwrt_n_i | input | 1 | Power-up delay enable, active low |
| cfg_bor_en_i | input | 1 | Brown-out detection enable |
| osc_mode_i | input | 2 | Oscillator mode: 0,1,2 crystal; 3 RC |
| rc_tick_i | input | 1 | One-cycle RC-oscillator tick strobe |
| sw_wr_i | input | 1 | Status register write strobe |
| sw_wdata_i | input | 2 | Status register write data |
| core_rst_o | output | 1 | Core reset, active high |
| phase_o | output | 2 | Sequence phase: 0 hold, 1 delay, 2 settling, 3 run |
| status_o | output | 2 | Reset-cause flags: bit 1 power-on, bit 0 brown-out |

## Verification
The bench sweeps all sixteen combinations of oscillator mode, delay enable and brown-out enable through a power-on. In each case it counts the delay ticks and settling cycles and compares them with the arithmetic expectation. A design that ignored brown-out enable when forcing the delay, or ran settling in RC mode, would show the wrong phase path. It also goes after the two counters' off-by-one edges. A second supply dip mid-delay must restart the count, so a design that resumes from the old count would finish early. A design that reran settling after brown-out would visit phase 2. A wake that dragged in the delay would visit phase 1. A pin that gated the timers would leave the core held long after the pin rises.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_START    = 3'd0,
        ST_HOLD     = 3'd1,
        ST_PWRT_POR = 3'd2,
        ST_PWRT_BOR = 3'd3,
        ST_OST      = 3'd4,
        ST_RUN      = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_PWRT = 2'd1,
        PH_OST  = 2'd2,
        PH_RUN  = 2'd3
    } phase_e;

    localparam logic [1:0] OSC_MODE_RC = 2'd3;

    function automatic phase_e phase_of(seq_state_e st);
        phase_e ph;
        unique case (st)
            ST_START, ST_HOLD:        ph = PH_HOLD;
            ST_PWRT_POR, ST_PWRT_BOR: ph = PH_PWRT;
            ST_OST:                   ph = PH_OST;
            ST_RUN:                   ph = PH_RUN;
            default:                  ph = PH_HOLD;
        endcase
        return ph;
    endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) chain_q <= {STAGES{RST_VAL}};
        else       chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic inc_i,
    output logic done_o
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign done_o = inc_i && (cnt_q == LAST);

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i)                 cnt_q <= '0;
        else if (clear_i || done_o) cnt_q <= '0;
        else if (inc_i)            cnt_q <= cnt_q + 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST); // R2

    AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        clear_i |=> cnt_q == '0); // R7
endmodule

// File: rtl/rst_seq_status.sv
module rst_seq_status (
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       bor_clr_i,
    input  logic       wr_i,
    input  logic [1:0] wdata_i,
    output logic [1:0] stat_o
);
    logic [1:0] stat_q;

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            stat_q <= 2'b00;
        end else begin
            if (wr_i)      stat_q    <= wdata_i;
            if (bor_clr_i) stat_q[0] <= 1'b0;
        end
    end

    assign stat_o = stat_q;

    AST_BOR_FLAG_CLR: assert property (@(posedge clk_i) disable iff (por_i)
        bor_clr_i |=> !stat_q[0]); // R11

    AST_POR_FLAG_KEEP: assert property (@(posedge clk_i) disable iff (por_i)
        !wr_i |=> $stable(stat_q[1])); // R11

    AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (por_i)
        wr_i |=> stat_q[1] == $past(wdata_i[1])); // R10
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int PWRT_TICKS  = 72,
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       supply_low_i,
    input  logic       mclr_n_i,
    input  logic       wake_i,
    input  logic       cfg_pwrt_n_i,
    input  logic       cfg_bor_en_i,
    input  logic [1:0] osc_mode_i,
    input  logic       rc_tick_i,
    input  logic       sw_wr_i,
    input  logic [1:0] sw_wdata_i,
    output logic       core_rst_o,
    output logic [1:0] phase_o,
    output logic [1:0] status_o
);
    seq_state_e state_q, state_d;

    logic pin_high;
    logic bor_hit;
    logic crystal;
    logic pwrt_on;
    logic in_pwrt;
    logic in_ost;
    logic pwrt_done;
    logic ost_done;

    rst_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
        .clk_i (clk_i),
        .rst_i (por_i),
        .d_i   (mclr_n_i),
        .q_o   (pin_high)
    );

    assign bor_hit = cfg_bor_en_i && supply_low_i;
    assign crystal = (osc_mode_i != OSC_MODE_RC);
    assign pwrt_on = !cfg_pwrt_n_i || cfg_bor_en_i;
    assign in_pwrt = (state_q == ST_PWRT_POR) || (state_q == ST_PWRT_BOR);
    assign in_ost  = (state_q == ST_OST);

    rst_seq_timer #(.LIMIT(PWRT_TICKS)) u_pwrt_timer (
        .clk_i   (clk_i),
        .rst_i   (por_i),
        .clear_i (!in_pwrt),
        .inc_i   (in_pwrt && rc_tick_i),
        .done_o  (pwrt_done)
    );

    rst_seq_timer #(.LIMIT(OST_CYCLES)) u_ost_timer (
        .clk_i   (clk_i),
        .rst_i   (por_i),
        .clear_i (!in_ost),
        .inc_i   (in_ost),
        .done_o  (ost_done)
    );

    // state register
    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) state_q <= ST_START;
        else       state_q <= state_d;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (bor_hit) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_START: begin
                    if (pwrt_on)      state_d = ST_PWRT_POR;
                    else if (crystal) state_d = ST_OST;
                    else              state_d = ST_RUN;
                end
                ST_HOLD:     state_d = ST_PWRT_BOR;
                ST_PWRT_POR: if (pwrt_done) state_d = crystal ? ST_OST : ST_RUN;
                ST_PWRT_BOR: if (pwrt_done) state_d = ST_RUN;
                ST_OST:      if (ost_done)  state_d = ST_RUN;
                ST_RUN:      if (wake_i && crystal) state_d = ST_OST;
                default:     state_d = ST_START;
            endcase
        end
    end

    // outputs
    always_comb begin
        phase_o    = phase_of(state_q);
        core_rst_o = !((state_q == ST_RUN) && pin_high);
    end

    rst_seq_status u_status (
        .clk_i     (clk_i),
        .por_i     (por_i),
        .bor_clr_i (bor_hit),
        .wr_i      (sw_wr_i),
        .wdata_i   (sw_wdata_i),
        .stat_o    (status_o)
    );

    AST_BOR_HOLD: assert property (@(posedge clk_i) disable iff (por_i)
        bor_hit |=> phase_o == PH_HOLD); // R6

    AST_OST_ENTRY: assert property (@(posedge clk_i) disable iff (por_i)
        (in_ost && $past(state_q) != ST_OST) |->
            ($past(state_q) == ST_START || $past(state_q) == ST_PWRT_POR
             || $past(state_q) == ST_RUN)); // R3

    AST_RC_NO_OST: assert property (@(posedge clk_i) disable iff (por_i)
        (osc_mode_i == OSC_MODE_RC && $past(osc_mode_i) == OSC_MODE_RC
         && $past(state_q) != ST_OST) |-> !in_ost); // R3

    AST_BOR_NO_OST: assert property (@(posedge clk_i) disable iff (por_i)
        (state_q == ST_PWRT_BOR) |=> (state_q != ST_OST)); // R6

    AST_RUN_STAYS: assert property (@(posedge clk_i) disable iff (por_i)
        (state_q == ST_RUN && !bor_hit && !wake_i) |=> state_q == ST_RUN); // R8

    AST_RELEASE_IN_RUN: assert property (@(posedge clk_i) disable iff (por_i)
        !core_rst_o |-> phase_o == PH_RUN); // R4
endmodule

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;
    localparam int PT     = 5;
    localparam int OC     = 8;
    localparam int RC_DIV = 3;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic supply_low = 1'b0;
    logic mclr_n = 1'b1;
    logic wake = 1'b0;
    logic cfg_pwrt_n = 1'b0;
    logic cfg_bor_en = 1'b0;
    logic [1:0] osc_mode = 2'd1;
    logic rc_tick = 1'b0;
    logic sw_wr = 1'b0;
    logic [1:0] sw_wdata = 2'b00;
    logic core_rst;
    logic [1:0] phase;
    logic [1:0] status;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    int rc_cnt = 0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        rc_cnt  <= (rc_cnt == RC_DIV - 1) ? 0 : rc_cnt + 1;
        rc_tick <= (rc_cnt == 0);
    end

    rst_seq_top #(.PWRT_TICKS(PT), .OST_CYCLES(OC), .SYNC_STAGES(2)) dut_i (
        .clk_i        (clk),
        .por_i        (por),
        .supply_low_i (supply_low),
        .mclr_n_i     (mclr_n),
        .wake_i       (wake),
        .cfg_pwrt_n_i (cfg_pwrt_n),
        .cfg_bor_en_i (cfg_bor_en),
        .osc_mode_i   (osc_mode),
        .rc_tick_i    (rc_tick),
        .sw_wr_i      (sw_wr),
        .sw_wdata_i   (sw_wdata),
        .core_rst_o   (core_rst),
        .phase_o      (phase),
        .status_o     (status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic sw_write(input logic [1:0] v);
        sw_wr = 1'b1;
        sw_wdata = v;
        step();
        sw_wr = 1'b0;
    endtask

    task automatic do_por();
        por = 1'b1;
        repeat (3) step();
        check(core_rst == 1'b1, "R1 core_rst", core_rst, 1);
        check(phase == 2'd0, "R1 phase", phase, 0);
        check(status[1] == 1'b0, "R1 por flag", status[1], 0);
        por = 1'b0;
    endtask

    // Walk until phase 3, counting delay ticks and settling cycles.
    task automatic run_seq(output int ticks, output int ost_cyc, output bit saw_p,
                           output bit saw_o, output bit order_ok);
        int guard;
        ticks = 0; ost_cyc = 0; saw_p = 0; saw_o = 0; order_ok = 1; guard = 0;
        while (guard < 2000) begin
            step();
            guard++;
            if (phase == 2'd1) begin
                saw_p = 1;
                if (saw_o) order_ok = 0;
                if (rc_tick) ticks++;
            end else if (phase == 2'd2) begin
                saw_o = 1;
                ost_cyc++;
            end else if (phase == 2'd3) begin
                break;
            end
        end
        check(phase == 2'd3, "R3 reached run", phase, 3);
    endtask

    initial begin
        int tk, oc;
        bit sp, so, ordok;
        step();
        // Sweep of every mode / delay enable / brown-out enable combination
        for (int m = 0; m < 4; m++) begin
            for (int pn = 0; pn < 2; pn++) begin
                for (int be = 0; be < 2; be++) begin
                    bit exp_p, exp_o;
                    osc_mode = 2'(m); cfg_pwrt_n = 1'(pn); cfg_bor_en = 1'(be);
                    mclr_n = 1'b1; supply_low = 1'b0;
                    por = 1'b0;
                    sw_write(2'b11);
                    do_por();
                    exp_p = (pn == 0) || (be == 1);
                    exp_o = (m != 3);
                    run_seq(tk, oc, sp, so, ordok);
                    check(sp == exp_p, "R2 delay used", sp, exp_p);
                    if (exp_p) check(tk == PT, "R2 delay ticks", tk, PT);
                    check(so == exp_o, "R3 settling used", so, exp_o);
                    if (exp_o) check(oc == OC, "R3 settling cycles", oc, OC);
                    check(ordok, "R3 settling after delay", ordok, 1);
                    repeat (2) step();
                    check(core_rst == 1'b0, "R4 released", core_rst, 0);
                end
            end
        end

        // R10 status writes
        sw_write(2'b10);
        check(status == 2'b10, "R10 write 10", status, 2);
        sw_write(2'b01);
        check(status == 2'b01, "R10 write 01", status, 1);

        // R5 / R4: pin low across the whole sequence
        osc_mode = 2'd1; cfg_pwrt_n = 1'b0; cfg_bor_en = 1'b0;
        mclr_n = 1'b0;
        do_por();
        run_seq(tk, oc, sp, so, ordok);
        check(tk == PT, "R5 delay ticks with pin low", tk, PT);
        check(oc == OC, "R5 settling with pin low", oc, OC);
        repeat (5) step();
        check(core_rst == 1'b1, "R5 held by pin", core_rst, 1);
        mclr_n = 1'b1;
        step();
        check(core_rst == 1'b1, "R4 sync stage 1", core_rst, 1);
        step();
        check(core_rst == 1'b0, "R4 release at second edge", core_rst, 0);

        // R6 / R7 / R11 brown-out
        osc_mode = 2'd1; cfg_pwrt_n = 1'b1; cfg_bor_en = 1'b1;
        do_por();
        run_seq(tk, oc, sp, so, ordok);
        sw_write(2'b11);
        supply_low = 1'b1;
        step();
        check(phase == 2'd0, "R6 hold on brown-out", phase, 0);
        check(core_rst == 1'b1, "R6 reset on brown-out", core_rst, 1);
        check(status == 2'b10, "R11 brown-out clears bit0 only", status, 2);
        repeat (10) step();
        check(phase == 2'd0, "R6 held while low", phase, 0);
        supply_low = 1'b0;
        run_seq(tk, oc, sp, so, ordok);
        check(tk == PT, "R6 delay after recovery", tk, PT);
        check(so == 1'b0, "R6 no settling after brown-out", so, 0);
        // dip in mid-delay
        supply_low = 1'b1;
        step();
        supply_low = 1'b0;
        tk = 0;
        while (tk < 2) begin
            step();
            if (phase == 2'd1 && rc_tick) tk++;
        end
        supply_low = 1'b1;
        step();
        check(phase == 2'd0, "R7 dip returns to hold", phase, 0);
        supply_low = 1'b0;
        run_seq(tk, oc, sp, so, ordok);
        check(tk == PT, "R7 delay restarted from zero", tk, PT);

        // R8 brown-out disabled
        osc_mode = 2'd3; cfg_pwrt_n = 1'b0; cfg_bor_en = 1'b0;
        do_por();
        run_seq(tk, oc, sp, so, ordok);
        sw_write(2'b11);
        supply_low = 1'b1;
        repeat (10) step();
        check(phase == 2'd3, "R8 phase unaffected", phase, 3);
        check(core_rst == 1'b0, "R8 reset unaffected", core_rst, 0);
        check(status == 2'b11, "R8 status unaffected", status, 3);
        supply_low = 1'b0;

        // R9 wake in RC mode ignored
        wake = 1'b1;
        step();
        wake = 1'b0;
        repeat (5) step();
        check(phase == 2'd3, "R9 wake ignored in RC", phase, 3);

        // R9 wake in crystal mode
        osc_mode = 2'd2;
        step();
        wake = 1'b1;
        step();
        wake = 1'b0;
        check(phase == 2'd2, "R9 wake enters settling", phase, 2);
        run_seq(tk, oc, sp, so, ordok);
        check(oc + 1 == OC, "R9 wake settling cycles", oc + 1, OC);
        check(sp == 1'b0, "R9 no delay on wake", sp, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule